// File: doc/BRIEF.md
# Interrupt Priority Resolver with Per-Core NMI Routing

This block watches a set of system interrupt request lines and, for one processor, names the single pending request that is most urgent. Each request carries a programmable two-bit urgency level. A lower level is more urgent, and level 0 is the most urgent of all. Among pending requests that share a level, the one with the smaller index is chosen. The chosen index and a valid flag are registered, so they appear one clock after the request lines change.

The same request lines also produce a non-maskable interrupt for each core. Each core has its own mask register with one bit per request line. A core's NMI output goes high whenever any request line is high and that core's mask bit for the line is set. This path is combinational from the request lines.

Levels and masks are loaded through a one-cycle write port. Addresses 0 to 7 select priority words. Each word packs four request lines, one per byte lane. Addresses 8 and up select the per-core mask words. All registers clear to zero on reset.

Top module: `irq_prio_nmi_router`

## Requirements
- R1: Among the requests pending at a clock edge, the one with the numerically lowest level is reported as the winner.
- R2: When several pending requests share the lowest level, the one with the smallest index wins.
- R3: The level of request n is held at write address n/4, in bits [8*(n%4)+7 : 8*(n%4)+6] of the data word. The other six bits of each byte lane are ignored.
- R4: `irq_valid_o` and `irq_id_o` are registered from the request lines, so they change on the first rising edge after the inputs change. `irq_valid_o` is 0 when no request is pending.
- R5: A level write is stored on the edge where `wr_en_i` is sampled high, and the winner reflects the new level on the following edge.
- R6: Write address 8+c holds the NMI mask of core c, with bit n belonging to request n. `nmi_o[c]` is high, without a clock delay, exactly when some request n is high and bit n of that mask is set.
- R7: After reset every level is 0 and every mask is 0. With all requests high, the winner is request 0 and every `nmi_o` bit is 0.
- R8: Writes to addresses 10 to 15 change neither the levels nor the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 26 | System interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| irq_valid_o | output | 1 | A request is pending |
| irq_id_o | output | 5 | Index of the winning request |
| nmi_o | output | 2 | Per-core non-maskable interrupt |

## Verification
The winner and its valid flag are due on the first rising edge after the request lines change. They are therefore sampled on the falling edge after that rising edge. A separate check, made just after the inputs change, confirms the old winner is still being held. A level write needs two edges before it shows in the winner: one edge stores the level and the next edge registers the new winner. The bench checks the old winner after the first edge and the new winner after the second. The NMI outputs carry no register, so they are checked one nanosecond after the request lines are driven, before any edge occurs.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_IRQ    = 26;
  localparam int NUM_CORES  = 2;
  localparam int PRIO_W     = 2;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int PRIO_SLOTS = 8;   // mask words start after the priority words
  localparam int LANES      = DATA_W / 8;
  localparam int ID_W       = $clog2(NUM_IRQ);
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_router_pkg::*;
#(
  parameter int N_IRQ   = NUM_IRQ,
  parameter int N_CORES = NUM_CORES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output logic [N_IRQ*PRIO_W-1:0]   levels_o,
  output logic [N_CORES*N_IRQ-1:0]  masks_o
);
  for (genvar n = 0; n < N_IRQ; n++) begin : g_lvl
    localparam int SLOT = n / LANES;
    localparam int MSB  = (n % LANES) * 8 + 8 - PRIO_W;  // level sits at top of lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        levels_o[n*PRIO_W +: PRIO_W] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(SLOT))
        levels_o[n*PRIO_W +: PRIO_W] <= wr_data_i[MSB +: PRIO_W];
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        masks_o[c*N_IRQ +: N_IRQ] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(PRIO_SLOTS + c))
        masks_o[c*N_IRQ +: N_IRQ] <= wr_data_i[N_IRQ-1:0];
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_router_pkg::*;
#(
  parameter int N_IRQ = NUM_IRQ,
  localparam int IW   = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]        pend_i,
  input  logic [N_IRQ*PRIO_W-1:0] levels_i,
  output logic                    found_o,
  output logic [IW-1:0]           id_o
);
  logic [PRIO_W-1:0] best_lvl;

  // Ascending scan with strict compare keeps the lowest index on a tie.
  always_comb begin
    found_o  = 1'b0;
    best_lvl = '1;
    id_o     = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend_i[i] && (!found_o || levels_i[i*PRIO_W +: PRIO_W] < best_lvl)) begin
        found_o  = 1'b1;
        best_lvl = levels_i[i*PRIO_W +: PRIO_W];
        id_o     = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nmi_gen.sv
module irq_nmi_gen
  import irq_router_pkg::*;
#(
  parameter int N_IRQ   = NUM_IRQ,
  parameter int N_CORES = NUM_CORES
) (
  input  logic [N_IRQ-1:0]         irq_i,
  input  logic [N_CORES*N_IRQ-1:0] masks_i,
  output logic [N_CORES-1:0]       nmi_o
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign nmi_o[c] = |(irq_i & masks_i[c*N_IRQ +: N_IRQ]);
  end
endmodule

// File: rtl/irq_prio_nmi_router.sv
module irq_prio_nmi_router
  import irq_router_pkg::*;
#(
  parameter int N_IRQ   = NUM_IRQ,
  parameter int N_CORES = NUM_CORES,
  localparam int IW     = $clog2(N_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               irq_valid_o,
  output logic [IW-1:0]      irq_id_o,
  output logic [N_CORES-1:0] nmi_o
);
  logic [N_IRQ*PRIO_W-1:0]  levels;
  logic [N_CORES*N_IRQ-1:0] masks;
  logic                     found;
  logic [IW-1:0]            win_id;

  irq_prio_regs #(.N_IRQ(N_IRQ), .N_CORES(N_CORES)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .levels_o(levels), .masks_o(masks)
  );

  irq_prio_resolver #(.N_IRQ(N_IRQ)) i_resolver (
    .pend_i(irq_i), .levels_i(levels), .found_o(found), .id_o(win_id)
  );

  irq_nmi_gen #(.N_IRQ(N_IRQ), .N_CORES(N_CORES)) i_nmi (
    .irq_i, .masks_i(masks), .nmi_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_id_o    <= '0;
    end else begin
      irq_valid_o <= found;
      irq_id_o    <= found ? win_id : '0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_IRQ   = 26,
  parameter int N_CORES = 2,
  localparam int IW     = $clog2(N_IRQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_IRQ-1:0]   irq_i,
  input logic               irq_valid_o,
  input logic [IW-1:0]      irq_id_o,
  input logic [N_CORES-1:0] nmi_o
);
  logic [N_IRQ-1:0] irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  p_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |=> !irq_valid_o);

  p_pend_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i != '0) |=> irq_valid_o);

  p_id_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (32'(irq_id_o) < N_IRQ));

  p_winner_pending_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && 32'(irq_id_o) < N_IRQ) |-> irq_q[irq_id_o]);

  p_nmi_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |-> (nmi_o == '0));
endmodule

bind irq_prio_nmi_router irq_router_chk #(.N_IRQ(N_IRQ), .N_CORES(N_CORES)) i_chk (.*);

// File: tb/test_irq_prio_nmi_router.sv
`timescale 1ns/1ps
module test_irq_prio_nmi_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        valid;
  logic [4:0]  id;
  logic [1:0]  nmi;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_nmi_router i_irq_prio_nmi_router (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_valid_o(valid), .irq_id_o(id), .nmi_o(nmi)
  );

  // {irq lines, expected valid, expected id}; levels set by program_levels
  localparam logic [31:0] VEC [12] = '{
    {26'h0000000, 1'b0, 5'd0},   // R4 nothing pending
    {26'h0000001, 1'b1, 5'd0},
    {26'h0000003, 1'b1, 5'd1},   // R1 lvl2 beats lvl3
    {26'h0000007, 1'b1, 5'd2},   // R1
    {26'h000000F, 1'b1, 5'd3},   // R1 lvl0
    {26'h0000011, 1'b1, 5'd4},   // R3 garbage low bits ignored
    {26'h0000110, 1'b1, 5'd8},   // R1
    {26'h0000300, 1'b1, 5'd8},   // R2 tie
    {26'h3000000, 1'b1, 5'd24},  // R2 tie
    {26'h2000004, 1'b1, 5'd2},   // R2 tie at lvl1
    {26'h2000020, 1'b1, 5'd25},  // R1
    {26'h2000000, 1'b1, 5'd25}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    chk("R7 valid", 32'(valid), 0);
    @(negedge clk) irq = '1;
    #1 chk("R7 nmi masked", 32'(nmi), 0);
    @(negedge clk);
    chk("R7 winner", {31'd0, valid, 5'd0} | 32'(id), {31'd0, 1'b1, 5'd0});

    // R3 program levels: irq0=3 irq1=2 irq2=1 irq3=0; irq4=2 (noisy low bits), irq5..7=3; irq24,25=1
    wr(4'd0, 32'h004080C0);
    wr(4'd1, 32'hC0C0C0BF);
    wr(4'd6, 32'h00004040);

    foreach (VEC[k]) begin
      @(negedge clk) irq = VEC[k][31:6];
      @(negedge clk);
      chk($sformatf("R1/R2/R3 vec%0d valid", k), 32'(valid), 32'(VEC[k][5]));
      chk($sformatf("R1/R2/R3 vec%0d id", k), 32'(id), 32'(VEC[k][4:0]));
    end

    // R4 output holds until the next edge
    @(negedge clk) irq = '0;
    #1 chk("R4 held before edge", 32'(valid), 1);
    @(negedge clk);
    chk("R4 idle", 32'(valid), 0);

    // R5 write latency: irq0 vs irq3, swap their levels
    @(negedge clk) irq = 26'h9;
    @(negedge clk) chk("R5 before", 32'(id), 3);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'hC0408000;
    @(negedge clk) wr_en = 1'b0;
    chk("R5 one edge", 32'(id), 3);
    @(negedge clk) chk("R5 two edges", 32'(id), 0);

    // R8 writes above the mask words ignored
    @(negedge clk) irq = 26'h110;
    wr(4'd10, 32'hFFFFFFFF);
    wr(4'd14, 32'hFFFFFFFF);
    @(negedge clk);
    chk("R8 winner kept", 32'(id), 8);
    chk("R8 nmi kept", 32'(nmi), 0);

    // R6 masks: core0 bit5, core1 bit20
    wr(4'd8, 32'h00000020);
    wr(4'd9, 32'h00100000);
    @(negedge clk) irq = 26'h0000020;
    #1 chk("R6 core0", 32'(nmi), 1);
    @(negedge clk) irq = 26'h0100000;
    #1 chk("R6 core1", 32'(nmi), 2);
    @(negedge clk) irq = 26'h0100020;
    #1 chk("R6 both", 32'(nmi), 3);
    @(negedge clk) irq = 26'h0000080;
    #1 chk("R6 unmasked line", 32'(nmi), 0);
    @(negedge clk) irq = '0;
    #1 chk("R6 quiet", 32'(nmi), 0);

    @(negedge clk);
    finish_run();
  end
endmodule